// File: doc/BRIEF.md
# Snooping MSI Shared-Bus Cache Model

This block models a small shared-memory multiprocessor: several processor ports, each with a private cache of a single line, all sharing one atomic bus to a central memory. A write-invalidate protocol with three line states (Invalid, Shared, Modified) keeps the caches coherent. Every cache watches every bus transaction. It invalidates or downgrades its own copy when needed. When it holds the dirty copy it supplies the data and writes it back.

A processor issues one read or write at a time through a valid/ready handshake and receives a one-cycle response carrying data. Reads that hit, and writes that hit a Modified line, are served locally without the bus. Every other access competes for the bus through a round-robin arbiter. The granted transaction completes atomically in one cycle, snoops and write-backs included. That serializes all writes to a location. The line state of each cache is visible on a status output so the protocol can be observed from outside.

Top module: `msi_snoop_system`

## Requirements
- R1: After reset every line reports Invalid (line_state code 0), every req_ready is high, and every memory word reads as zero.
- R2: A read miss fetches the word and leaves the reader's line Shared (code 1), with rsp_hit low. Other caches already Shared on that address stay Shared.
- R3: A write that misses, or that finds its line only Shared, uses the bus. Every other cache holding that address goes Invalid, and the writer's line goes Modified (code 2) with rsp_hit low.
- R4: A write to an address whose line is already Modified completes without the bus: rsp_hit high, line stays Modified.
- R5: A read of an address that another cache holds Modified returns that cache's current value. The holder drops to Shared and the reader installs the line Shared.
- R6: A read that hits a Shared line completes locally with rsp_hit high and no change of state in any cache.
- R7: An access to a different address replaces the resident line. A Modified victim is written back to memory in the same bus transaction. Caches holding other addresses keep their state.
- R8: Every read returns the most recently written value of its address, whichever port wrote it. The response to a write returns the written data.
- R9: The bus goes to one requester per cycle, in round-robin order. After reset the pointer starts at port 0, so simultaneous requests complete on consecutive cycles in the order 0,1,2,3.
- R10: req_ready is low from acceptance until the response. rsp_valid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_ready | output | NPORT | Port idle and able to accept a request |
| req_write | input | NPORT | 1 = write, 0 = read, per port |
| req_addr | input | NPORT*ADDR_W | Word address, port i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NPORT*DATA_W | Write data, port i at bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | NPORT | One-cycle response pulse per port |
| rsp_hit | output | NPORT | Response was served without a bus transaction |
| rsp_rdata | output | NPORT*DATA_W | Read data, or written data for a write |
| line_state | output | NPORT*2 | Line state per port: 0 Invalid, 1 Shared, 2 Modified |

## Verification
The bench uses the defaults: four ports, a three-bit address and sixteen-bit data. Four ports allow a three-way Shared set while a fourth port writes, and they let one burst of simultaneous writes walk the arbiter through a full rotation. Eight addresses leave room to evict a dirty line to one address while a second address stays Modified in another cache. That shows both the write-back and the isolation of snoops to other addresses.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_PEND = 2'd1,
        CS_RESP = 2'd2
    } ctl_st_t;

    localparam int unsigned LINE_ST_W = 2;

    // Local service possible: valid copy of the right address, and for a write, ownership.
    function automatic logic msi_local_hit(line_st_t st, logic same_tag, logic is_wr);
        return (st != LN_INV) && same_tag && (!is_wr || st == LN_MOD);
    endfunction

    // State of a copy after another cache's transaction on the same address.
    function automatic line_st_t msi_snoop_next(line_st_t st, logic bus_excl);
        if (bus_excl)
            return LN_INV;
        else if (st == LN_MOD)
            return LN_SHR;
        else
            return st;
    endfunction

endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    int            winner;

    always_comb begin
        gnt    = '0;
        winner = -1;
        for (int k = 0; k < int'(N); k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % int'(N);
            if (winner < 0 && req[idx]) begin
                gnt[idx] = 1'b1;
                winner   = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (winner >= 0)
            ptr_q <= PW'((winner + 1) % int'(N));
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R9
    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R9
    AST_NO_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt)); // R9

endmodule

// File: rtl/msi_mem.sv
module msi_mem #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_we,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              sp_we,
    input  logic [ADDR_W-1:0] sp_addr,
    input  logic [DATA_W-1:0] sp_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++)
                mem_q[i] <= '0;
        end else begin
            if (ev_we)
                mem_q[ev_addr] <= ev_data;
            if (sp_we)
                mem_q[sp_addr] <= sp_data;
        end
    end

    // A victim never shares the address of the word being fetched.
    AST_WB_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (ev_we && sp_we) |-> (ev_addr != sp_addr)); // R7

endmodule

// File: rtl/msi_line_ctl.sv
module msi_line_ctl
    import msi_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    // processor side
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output line_st_t          st_o,
    output logic [ADDR_W-1:0] tag_o,
    // bus side
    output logic              breq,
    output logic              breq_wr,
    output logic [ADDR_W-1:0] breq_addr,
    input  logic              gnt,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_fill,
    output logic              sup,
    output logic [DATA_W-1:0] sup_data,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);
    typedef struct packed {
        line_st_t          st;
        logic [ADDR_W-1:0] tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } op_t;

    ctl_st_t           ctl_q, ctl_d;
    op_t               op_q, op_d;
    line_t             line_q, line_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              rhit_q, rhit_d;

    logic hit, snoop_me, hit_ok;

    always_comb begin
        hit      = msi_local_hit(line_q.st, line_q.tag == op_q.addr, op_q.wr);
        snoop_me = bus_valid && !gnt && line_q.st != LN_INV && line_q.tag == bus_addr;
        hit_ok   = ctl_q == CS_PEND && hit && !snoop_me;
    end

    always_comb begin
        ctl_d   = ctl_q;
        op_d    = op_q;
        line_d  = line_q;
        rdata_d = rdata_q;
        rhit_d  = rhit_q;
        case (ctl_q)
            CS_IDLE: if (req_valid) begin
                op_d  = '{wr: req_write, addr: req_addr, wdata: req_wdata};
                ctl_d = CS_PEND;
            end
            CS_PEND: if (hit_ok) begin
                if (op_q.wr)
                    line_d.data = op_q.wdata;
                rdata_d = op_q.wr ? op_q.wdata : line_q.data;
                rhit_d  = 1'b1;
                ctl_d   = CS_RESP;
            end else if (gnt) begin
                line_d.tag  = op_q.addr;
                line_d.st   = op_q.wr ? LN_MOD : LN_SHR;
                line_d.data = op_q.wr ? op_q.wdata : bus_fill;
                rdata_d     = op_q.wr ? op_q.wdata : bus_fill;
                rhit_d      = 1'b0;
                ctl_d       = CS_RESP;
            end
            CS_RESP: ctl_d = CS_IDLE;
            default: ctl_d = CS_IDLE;
        endcase
        if (snoop_me)
            line_d.st = msi_snoop_next(line_q.st, bus_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CS_IDLE;
            op_q    <= '0;
            line_q  <= '{st: LN_INV, tag: '0, data: '0};
            rdata_q <= '0;
            rhit_q  <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            op_q    <= op_d;
            line_q  <= line_d;
            rdata_q <= rdata_d;
            rhit_q  <= rhit_d;
        end
    end

    assign req_ready = ctl_q == CS_IDLE;
    assign rsp_valid = ctl_q == CS_RESP;
    assign rsp_hit   = rhit_q;
    assign rsp_rdata = rdata_q;
    assign st_o      = line_q.st;
    assign tag_o     = line_q.tag;

    assign breq      = ctl_q == CS_PEND && !hit;
    assign breq_wr   = op_q.wr;
    assign breq_addr = op_q.addr;

    assign sup       = bus_valid && !gnt && line_q.st == LN_MOD && line_q.tag == bus_addr;
    assign sup_data  = line_q.data;
    assign ev_valid  = gnt && line_q.st == LN_MOD;
    assign ev_addr   = line_q.tag;
    assign ev_data   = line_q.data;

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> !req_ready); // R10
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        gnt |-> breq); // R9
    AST_FILL_STATE: assert property (@(posedge clk) disable iff (rst)
        gnt |=> (line_q.tag == op_q.addr &&
                 line_q.st == (op_q.wr ? LN_MOD : LN_SHR))); // R2 R3
    AST_SNOOP_INVAL: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wr && !gnt && line_q.st != LN_INV && line_q.tag == bus_addr)
        |=> line_q.st == LN_INV); // R3
    AST_SNOOP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_wr && !gnt && line_q.st == LN_MOD && line_q.tag == bus_addr)
        |=> line_q.st == LN_SHR); // R5
    AST_OTHER_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !gnt && line_q.tag != bus_addr && ctl_q != CS_PEND)
        |=> $stable(line_q.st)); // R7

endmodule

// File: rtl/msi_snoop_system.sv
module msi_snoop_system
    import msi_pkg::*;
#(
    parameter int unsigned NPORT  = 4,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0]         req_valid,
    output logic [NPORT-1:0]         req_ready,
    input  logic [NPORT-1:0]         req_write,
    input  logic [NPORT*ADDR_W-1:0]  req_addr,
    input  logic [NPORT*DATA_W-1:0]  req_wdata,
    output logic [NPORT-1:0]         rsp_valid,
    output logic [NPORT-1:0]         rsp_hit,
    output logic [NPORT*DATA_W-1:0]  rsp_rdata,
    output logic [NPORT*LINE_ST_W-1:0] line_state
);
    logic [NPORT-1:0]  breq, breq_wr, gnt, sup, ev_valid;
    logic [ADDR_W-1:0] breq_addr [NPORT];
    logic [ADDR_W-1:0] ev_addr   [NPORT];
    logic [ADDR_W-1:0] tag       [NPORT];
    logic [DATA_W-1:0] sup_data  [NPORT];
    logic [DATA_W-1:0] ev_data   [NPORT];
    line_st_t          st        [NPORT];

    logic              bus_valid, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_fill, mem_rd;
    logic              sup_any, ev_we;
    logic [DATA_W-1:0] sup_word, ev_word;
    logic [ADDR_W-1:0] ev_where;

    msi_rr_arb #(.N(NPORT)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (breq),
        .gnt (gnt)
    );

    always_comb begin
        bus_valid = |gnt;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        sup_any   = |sup;
        sup_word  = '0;
        ev_we     = |ev_valid;
        ev_word   = '0;
        ev_where  = '0;
        for (int i = 0; i < int'(NPORT); i++) begin
            if (gnt[i]) begin
                bus_wr   = bus_wr | breq_wr[i];
                bus_addr = bus_addr | breq_addr[i];
            end
            if (sup[i])
                sup_word = sup_word | sup_data[i];
            if (ev_valid[i]) begin
                ev_word  = ev_word | ev_data[i];
                ev_where = ev_where | ev_addr[i];
            end
        end
        bus_fill = sup_any ? sup_word : mem_rd;
    end

    msi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (bus_addr),
        .rd_data (mem_rd),
        .ev_we   (ev_we),
        .ev_addr (ev_where),
        .ev_data (ev_word),
        .sp_we   (sup_any),
        .sp_addr (bus_addr),
        .sp_data (sup_word)
    );

    for (genvar i = 0; i < int'(NPORT); i++) begin : g_port
        msi_line_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid[i]),
            .req_ready (req_ready[i]),
            .req_write (req_write[i]),
            .req_addr  (req_addr[i*ADDR_W +: ADDR_W]),
            .req_wdata (req_wdata[i*DATA_W +: DATA_W]),
            .rsp_valid (rsp_valid[i]),
            .rsp_hit   (rsp_hit[i]),
            .rsp_rdata (rsp_rdata[i*DATA_W +: DATA_W]),
            .st_o      (st[i]),
            .tag_o     (tag[i]),
            .breq      (breq[i]),
            .breq_wr   (breq_wr[i]),
            .breq_addr (breq_addr[i]),
            .gnt       (gnt[i]),
            .bus_valid (bus_valid),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_fill  (bus_fill),
            .sup       (sup[i]),
            .sup_data  (sup_data[i]),
            .ev_valid  (ev_valid[i]),
            .ev_addr   (ev_addr[i]),
            .ev_data   (ev_data[i])
        );
        assign line_state[i*LINE_ST_W +: LINE_ST_W] = st[i];

        for (genvar j = i + 1; j < int'(NPORT); j++) begin : g_pair
            // A Modified copy is the only valid copy of its address.
            AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
                !(tag[i] == tag[j] &&
                  ((st[i] == LN_MOD && st[j] != LN_INV) ||
                   (st[j] == LN_MOD && st[i] != LN_INV)))); // R8
        end
    end

    AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sup)); // R5

endmodule

// File: tb/msi_snoop_system_test.sv
`timescale 1ns/100ps
module msi_snoop_system_test;
    localparam int NP = 4;
    localparam int AW = 3;
    localparam int DW = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_ready;
    logic [NP-1:0]    req_write = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    rsp_valid;
    logic [NP-1:0]    rsp_hit;
    logic [NP*DW-1:0] rsp_rdata;
    logic [NP*2-1:0]  line_state;

    msi_snoop_system #(.NPORT(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_rdata  (rsp_rdata),
        .line_state (line_state)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [DW-1:0] data;
        logic          hit;
        string         rq;
    } exp_t;

    exp_t          sb [NP][$];
    logic [DW-1:0] ref_mem [1 << AW];
    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;
    int            rsp_cyc [NP];
    logic [NP-1:0] prev_rsp = '0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (prev_rsp[p] && rsp_valid[p])
                    check(0, "R10", $sformatf("port%0d rsp_valid longer than one cycle", p), 1, 0);
                if (rsp_valid[p]) begin
                    rsp_cyc[p] = cyc;
                    if (sb[p].size() == 0) begin
                        check(0, "R10", $sformatf("port%0d unexpected response", p), 1, 0);
                    end else begin
                        exp_t e;
                        e = sb[p].pop_front();
                        check(rsp_rdata[p*DW +: DW] == e.data, e.rq,
                              $sformatf("port%0d rdata", p), rsp_rdata[p*DW +: DW], e.data);
                        check(rsp_hit[p] == e.hit, e.rq,
                              $sformatf("port%0d rsp_hit", p), rsp_hit[p], e.hit);
                    end
                end
            end
            prev_rsp = rsp_valid;
        end else begin
            prev_rsp = '0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(0, "R10", "watchdog expired", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < (1 << AW); a++) ref_mem[a] = '0;
    endtask

    task automatic push_exp(input int p, input bit w, input int a,
                            input logic [DW-1:0] d, input bit h, input string rq);
        exp_t e;
        e.data = w ? d : ref_mem[a];
        e.hit  = h;
        e.rq   = rq;
        if (w) ref_mem[a] = d;
        sb[p].push_back(e);
        req_valid[p]           = 1'b1;
        req_write[p]           = w;
        req_addr[p*AW +: AW]   = AW'(a);
        req_wdata[p*DW +: DW]  = d;
    endtask

    task automatic issue(input int p, input bit w, input int a,
                         input logic [DW-1:0] d, input bit h, input string rq);
        @(negedge clk);
        push_exp(p, w, a, d, h, rq);
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        check(req_ready[p] == 1'b0, "R10", $sformatf("port%0d ready while busy", p),
              req_ready[p], 0);
        while (sb[p].size() != 0) @(negedge clk);
    endtask

    task automatic chk_state(input int p, input int exp, input string rq);
        check(int'(line_state[p*2 +: 2]) == exp, rq, $sformatf("port%0d line state", p),
              line_state[p*2 +: 2], exp);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            chk_state(p, 0, "R1");
            check(req_ready[p] == 1'b1, "R1", $sformatf("port%0d ready after reset", p),
                  req_ready[p], 1);
        end
        // R1 R2: read miss from zeroed memory
        issue(0, 0, 2, 16'h0, 0, "R1");
        chk_state(0, 1, "R2");
        issue(1, 0, 2, 16'h0, 0, "R2");
        chk_state(0, 1, "R2");
        chk_state(1, 1, "R2");
        // R6: read hit on Shared
        issue(0, 0, 2, 16'h0, 1, "R6");
        chk_state(0, 1, "R6");
        chk_state(1, 1, "R6");
        // R3: write invalidates the sharers
        issue(2, 1, 2, 16'h1111, 0, "R3");
        chk_state(2, 2, "R3");
        chk_state(0, 0, "R3");
        chk_state(1, 0, "R3");
        // R4: write hit on Modified
        issue(2, 1, 2, 16'h2222, 1, "R4");
        chk_state(2, 2, "R4");
        // R5: read of a Modified word held elsewhere
        issue(3, 0, 2, 16'h0, 0, "R5");
        chk_state(2, 1, "R5");
        chk_state(3, 1, "R5");
        // R3: upgrade from Shared
        issue(2, 1, 2, 16'h3333, 0, "R3");
        chk_state(2, 2, "R3");
        chk_state(3, 0, "R3");
        // R7: other address leaves port2 alone
        issue(1, 1, 6, 16'h4444, 0, "R7");
        chk_state(1, 2, "R7");
        chk_state(2, 2, "R7");
        // R7: dirty eviction, then R8 value survives through memory
        issue(2, 0, 5, 16'h0, 0, "R7");
        chk_state(2, 1, "R7");
        chk_state(1, 2, "R7");
        issue(0, 0, 2, 16'h0, 0, "R8");
        chk_state(0, 1, "R8");
        issue(3, 0, 6, 16'h0, 0, "R5");
        chk_state(1, 1, "R5");
        chk_state(3, 1, "R5");

        // R1: second reset clears lines and memory
        do_reset();
        for (int p = 0; p < NP; p++) chk_state(p, 0, "R1");
        issue(2, 0, 6, 16'h0, 0, "R1");

        // R9: simultaneous writes to one address, arbiter pointer back at port 0
        do_reset();
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            push_exp(p, 1, 5, DW'(16'hA000 + p), 0, "R9");
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        for (int p = 0; p < NP; p++)
            while (sb[p].size() != 0) @(negedge clk);
        for (int p = 1; p < NP; p++)
            check(rsp_cyc[p] == rsp_cyc[0] + p, "R9", $sformatf("port%0d completion slot", p),
                  rsp_cyc[p] - rsp_cyc[0], p);
        for (int p = 0; p < NP - 1; p++) chk_state(p, 0, "R9");
        chk_state(NP - 1, 2, "R9");
        // R8: last serialized write is what everyone sees
        issue(0, 0, 5, 16'h0, 0, "R8");
        issue(1, 0, 5, 16'h0, 0, "R8");
        chk_state(NP - 1, 1, "R8");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule